// File: doc/BRIEF.md
# Byte-Addressed Two-Wire Configuration Memory

This block is a 256-byte memory that answers as a target on a two-wire I2C/SMBus bus. The bus pins are oversampled by the system clock. The block recognises its own 7-bit address, acknowledges it, and then serves one of two transfers. In a write transfer, the first data byte sets an internal byte pointer, and each later byte is stored at the pointer, which then moves forward. In a read transfer, the block returns the byte at the pointer and moves the pointer forward, once per byte, for as long as the controller keeps acknowledging.

A soft reset input reloads every byte from a flat initial-image input and returns the pointer to zero. Written data is therefore lost on each soft reset. A separate power-on reset also clears a sticky flag. That flag goes high at the first acknowledged data byte in either direction, and the soft reset does not clear it. Up to eight copies can share one bus, each one selected by its instance index.

Top module: `smbus_eeprom`

## Requirements
- R1: While rst_n is low, byte k of the array is loaded from init_image[8k+7:8k] and the pointer is set to 0. Data written before the soft reset does not survive it.
- R2: The target address is 7'h50 plus dev_index (0 to 7). For that address, the block pulls SDA low during the ninth clock of the address byte, for both the write direction and the read direction.
- R3: An address byte carrying any other address gets no acknowledge, and SDA stays released. Such a transfer leaves the accessed flag, the pointer and the memory unchanged.
- R4: In a write transfer, the first data byte is loaded into the pointer. Each later byte is stored at the pointer, and the pointer then increments. The block acknowledges every data byte.
- R5: In a read transfer, the block shifts out the byte at the pointer, MSB first, and then increments the pointer. It continues with the next byte while the controller acknowledges, and stops sending after a controller NACK.
- R6: The pointer wraps from 255 to 0 in both write transfers and read transfers.
- R7: The accessed output rises at the first acknowledged data byte in either direction. Only por_n clears it; rst_n does not.
- R8: A STOP or a repeated START ends the current transfer. The pointer keeps its value from one transfer to the next.
- R9: SCL and SDA each pass through two flip-flops. START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high. A repeated START is accepted in the middle of a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| por_n | input | 1 | Power-on reset, active low; also clears accessed |
| rst_n | input | 1 | Soft reset, active low; reloads the image and zeroes the pointer |
| dev_index | input | 3 | Instance index added to the base address |
| init_image | input | 2048 | Initial contents; byte k is held in bits 8k+7..8k |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| accessed | output | 1 | Sticky flag: set by any served data byte |

## Verification
The hardest case to reach is the pointer wrap inside one transfer, with no reset in between. The bench first writes three bytes starting at offset 254, so the last write lands at offset 0. It then sets the pointer back to 254 with a write that has no data bytes and reads four bytes in one transfer. The read has to return the three written bytes, followed by the untouched image byte at offset 1. The bench also drives a repeated START straight after the acknowledge of a pointer byte and checks that the following read begins at that pointer.

// File: rtl/smbus_eeprom.sv
module smbus_eeprom #(
  parameter int         MEM_BYTES = 256,
  parameter int         IDX_W     = 3,
  parameter logic [6:0] BASE_ADDR = 7'h50
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       dev_index,
  input  logic [MEM_BYTES*8-1:0] init_image,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic                   accessed
);
  localparam int OFS_W = $clog2(MEM_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} state_t;

  state_t           state;
  logic [1:0]       scl_ff, sda_ff;
  logic             scl_q, sda_q;
  logic [7:0]       rx, tx;
  logic [3:0]       bit_cnt;
  logic             rw, first, mnack;
  logic [OFS_W-1:0] offset;
  logic [7:0]       mem [MEM_BYTES];

  wire scl_s = scl_ff[1];
  wire sda_s = sda_ff[1];
  wire live  = por_n & rst_n;

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  wire [6:0] my_addr = BASE_ADDR + 7'(dev_index);

  wire addr_done = (state == S_ADDR) && scl_fall && (bit_cnt == 4'd8);
  wire addr_hit  = addr_done && (rx[7:1] == my_addr);
  wire wr_commit = live && (state == S_WR) && scl_fall && (bit_cnt == 4'd8);
  wire store     = wr_commit && !first;
  wire rd_load   = live && scl_fall &&
                   (((state == S_AACK) && rw) || ((state == S_RACK) && !mnack));

  assign sda_oe = (state == S_AACK) || (state == S_WACK) || ((state == S_RD) && !tx[7]);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!live) begin
      state   <= S_IDLE;
      rx      <= '0;
      tx      <= 8'hFF;
      bit_cnt <= '0;
      rw      <= 1'b0;
      first   <= 1'b0;
      mnack   <= 1'b1;
    end else if (start_det) begin
      state   <= S_ADDR;
      bit_cnt <= '0;
      tx      <= 8'hFF;
    end else if (stop_det) begin
      state   <= S_IDLE;
      tx      <= 8'hFF;
    end else begin
      unique case (state)
        S_ADDR: begin
          if (scl_rise) begin
            rx      <= {rx[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (addr_done) begin
            state   <= addr_hit ? S_AACK : S_IDLE;
            rw      <= rx[0];
            bit_cnt <= '0;
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              tx    <= mem[offset];
              state <= S_RD;
            end else begin
              first <= 1'b1;
              state <= S_WR;
            end
          end
        end
        S_WR: begin
          if (scl_rise) begin
            rx      <= {rx[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (wr_commit) begin
            first   <= 1'b0;
            bit_cnt <= '0;
            state   <= S_WACK;
          end
        end
        S_WACK: begin
          if (scl_fall) state <= S_WR;
        end
        S_RD: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              tx      <= 8'hFF;
              bit_cnt <= '0;
              state   <= S_RACK;
            end else begin
              tx      <= {tx[6:0], 1'b1};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mnack <= sda_s;
          end else if (scl_fall) begin
            if (mnack) begin
              state <= S_IDLE;
            end else begin
              tx    <= mem[offset];
              state <= S_RD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!live) begin
      for (int k = 0; k < MEM_BYTES; k++) mem[k] <= init_image[8*k +: 8];
    end else if (store) begin
      mem[offset] <= rx;
    end
  end

  always_ff @(posedge clk) begin
    if (!live)                    offset <= '0;
    else if (wr_commit && first)  offset <= rx[OFS_W-1:0];
    else if (store || rd_load)    offset <= offset + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n)                        accessed <= 1'b0;
    else if (wr_commit || rd_load)     accessed <= 1'b1;
  end

  AST_ACC_STICKY:    assert property (@(posedge clk) disable iff (!por_n) accessed |=> accessed); // R7
  AST_RST_OFS_ZERO:  assert property (@(posedge clk) disable iff (!por_n) !rst_n |=> (offset == '0)); // R1
  AST_FOREIGN_NACK:  assert property (@(posedge clk) disable iff (!live) (addr_done && !addr_hit) |=> !sda_oe); // R3
  AST_PTR_FROM_BYTE: assert property (@(posedge clk) disable iff (!live) (wr_commit && first) |=> (offset == $past(rx[OFS_W-1:0]))); // R4
  AST_RD_ADVANCE:    assert property (@(posedge clk) disable iff (!live) rd_load |=> (offset == OFS_W'($past(offset) + 1'b1))); // R6
  AST_START_ADDR:    assert property (@(posedge clk) disable iff (!live) start_det |=> (state == S_ADDR && bit_cnt == 4'd0)); // R9
endmodule

// File: tb/smbus_eeprom_bench.sv
module smbus_eeprom_bench;
  localparam int T = 8;

  typedef struct { logic [7:0] val; string tag; } exp_t;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic [2:0]  dev_index = 3'd3;
  logic [2047:0] init_image;
  logic        scl = 1'b1, sda_m = 1'b1;
  logic        sda_oe, accessed;
  wire         sda = sda_m & ~sda_oe;

  logic [7:0]  img [256];
  logic [7:0]  ref_mem [256];
  logic [7:0]  ref_ofs;
  exp_t        exp_q [$];
  logic [7:0]  got_q [$];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  smbus_eeprom u_smbus_eeprom (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .dev_index(dev_index),
    .init_image(init_image), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .accessed(accessed)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); sda_m = 1'b0; tick(T); scl = 1'b0; tick(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(T); scl = 1'b1; tick(T); sda_m = 1'b1; tick(T);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(T); scl = 1'b1; tick(T); scl = 1'b0;
    end
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T/2); ack = sda; tick(T/2); scl = 1'b0; tick(T);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(T); scl = 1'b1; tick(T/2); b[i] = sda; tick(T/2); scl = 1'b0;
    end
    sda_m = nack; tick(T); scl = 1'b1; tick(T); scl = 1'b0; tick(T); sda_m = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] ofs, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                        input bit keep, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({a, 1'b0}, ack);
    check(ack == 1'b0, "R2 write address ack", {7'd0, ack}, 8'd0);
    send_byte(ofs, ack);
    check(ack == 1'b0, {tag, " pointer byte ack"}, {7'd0, ack}, 8'd0);
    ref_ofs = ofs;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      send_byte(d, ack);
      check(ack == 1'b0, {tag, " data byte ack"}, {7'd0, ack}, 8'd0);
      ref_mem[ref_ofs] = d;
      ref_ofs = ref_ofs + 8'd1;
    end
    if (!keep) bus_stop();
  endtask

  task automatic rd_txn(input logic [6:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    exp_t e;
    bus_start();
    send_byte({a, 1'b1}, ack);
    check(ack == 1'b0, "R2 read address ack", {7'd0, ack}, 8'd0);
    for (int i = 0; i < n; i++) begin
      e.val = ref_mem[ref_ofs];
      e.tag = tag;
      exp_q.push_back(e);
      ref_ofs = ref_ofs + 8'd1;
      recv_byte(i == n - 1, b);
      got_q.push_back(b);
    end
    bus_stop();
  endtask

  task automatic foreign(input logic [6:0] a, input bit rd, input string tag);
    logic ack;
    bus_start();
    send_byte({a, rd}, ack);
    check(ack == 1'b1, tag, {7'd0, ack}, 8'd1);
    bus_stop();
  endtask

  initial begin : monitor
    exp_t e;
    logic [7:0] g;
    forever begin
      @(negedge clk);
      if (got_q.size() > 0) begin
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          check(1'b0, "scoreboard unexpected byte", g, 8'h00);
        end else begin
          e = exp_q.pop_front();
          check(g == e.val, e.tag, g, e.val);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int k = 0; k < 256; k++) begin
      img[k] = 8'((k * 37 + 11) ^ (k >> 3));
      init_image[8*k +: 8] = img[k];
      ref_mem[k] = img[k];
    end
    ref_ofs = 8'd0;
    tick(5); por_n = 1'b1; tick(3); rst_n = 1'b1; tick(5);

    check(accessed == 1'b0, "R7 accessed clear after power-on", {7'd0, accessed}, 8'd0);
    check(sda_oe == 1'b0, "R1 SDA released after reset", {7'd0, sda_oe}, 8'd0);

    foreign(7'h50, 1'b0, "R3 foreign write address nack");
    foreign(7'h54, 1'b1, "R3 foreign read address nack");
    check(accessed == 1'b0, "R3 accessed untouched by foreign address", {7'd0, accessed}, 8'd0);

    rd_txn(7'h53, 3, "R5 sequential read from pointer 0");
    check(accessed == 1'b1, "R7 accessed set by read", {7'd0, accessed}, 8'd1);

    wr_txn(7'h53, 8'hFE, 3, 8'hA1, 8'hB2, 8'hC3, 1'b0, "R4");
    rd_txn(7'h53, 1, "R8 pointer kept across transfers");
    wr_txn(7'h53, 8'hFE, 0, 8'h00, 8'h00, 8'h00, 1'b0, "R4");
    rd_txn(7'h53, 4, "R6 wrap over 255 in write and read");

    wr_txn(7'h53, 8'h40, 1, 8'h99, 8'h00, 8'h00, 1'b1, "R4");
    wr_txn(7'h53, 8'h3F, 0, 8'h00, 8'h00, 8'h00, 1'b1, "R9");
    rd_txn(7'h53, 2, "R9 repeated start keeps pointer");

    rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    for (int k = 0; k < 256; k++) ref_mem[k] = img[k];
    ref_ofs = 8'd0;
    check(accessed == 1'b1, "R7 soft reset keeps accessed", {7'd0, accessed}, 8'd1);
    rd_txn(7'h53, 1, "R1 pointer zero after soft reset");
    wr_txn(7'h53, 8'hFE, 0, 8'h00, 8'h00, 8'h00, 1'b0, "R4");
    rd_txn(7'h53, 2, "R1 image restored over written bytes");

    dev_index = 3'd7; tick(4);
    foreign(7'h53, 1'b1, "R2 old address nack after index change");
    rd_txn(7'h57, 1, "R2 index 7 answers at 0x57");

    tick(4 * T);
    check(exp_q.size() == 0, "R5 scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule